// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block drives the three status lamps of a 10/100 twisted-pair PHY: one for link presence, one for line speed and one for traffic. Every lamp output is active low, so a 0 lights the lamp. The link and speed lamps follow the PHY's link-up and speed flags directly. The traffic lamp is driven by a small blink engine that turns short activity pulses into visible flashes.

Each transmit or receive pulse first passes a packet-class filter. Outside wake-on-LAN operation every pulse counts. In wake-on-LAN operation, a configuration bit decides whether broadcast frames count as activity along with frames whose individual address matches, or whether only individual-address matches count. An accepted pulse starts a lit period followed by a forced dark period. Pulses that arrive inside that window are folded into a single pending flash. Sparse traffic therefore gives isolated flashes, and dense traffic gives a steady blink at the fastest rate, so the flicker rate follows the load.

All inputs are plain level or pulse signals that are sampled on the rising clock edge. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `phy_led_ctrl`

## Requirements
- R1: All three lamp outputs are active low: 0 means lit and 1 means dark.
- R2: `link_led_n` is 0 exactly when `link_up` is 1, whatever the value of `speed_100`.
- R3: `speed_led_n` is 0 exactly when `link_up` is 1 and `speed_100` is 1, and is 1 at 10 Mb/s.
- R4: With no accepted activity, `act_led_n` stays 1. An accepted pulse sampled at a clock edge lights the lamp from that edge for exactly ON_CYC cycles. The lamp is then dark for at least OFF_CYC cycles.
- R5: Accepted pulses that arrive during the lit or dark window of a flash are merged into one pending flash. That flash starts on the edge at which the dark period ends. Sustained traffic therefore blinks with period ON_CYC+OFF_CYC, with the lamp lit for the first ON_CYC cycles of each period.
- R6: When `wol_mode` is 0, every `tx_act` or `rx_act` pulse is accepted, whatever the values of `pkt_bcast` and `pkt_ucast`.
- R7: When `wol_mode` is 1 and `wol_ucast_only` is 0, a pulse is accepted if `pkt_bcast` or `pkt_ucast` is 1, and is ignored if both are 0.
- R8: When `wol_mode` is 1 and `wol_ucast_only` is 1, a pulse is accepted only if `pkt_ucast` is 1. A broadcast-only pulse is ignored.
- R9: While `link_up` is 0, `speed_led_n` and `act_led_n` are 1, activity pulses are ignored, and any flash in progress or pending is cancelled. When the link returns, the lamp resumes nothing.
- R10: While `rst_n` is 0, the blink engine is idle and `act_led_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link present |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| wol_mode | input | 1 | Wake-on-LAN operation |
| pkt_bcast | input | 1 | Current frame is a broadcast match |
| pkt_ucast | input | 1 | Current frame is an individual-address match |
| wol_ucast_only | input | 1 | In wake-on-LAN operation, accept individual-address matches only |
| link_led_n | output | 1 | Link lamp, active low |
| speed_led_n | output | 1 | Speed lamp, active low |
| act_led_n | output | 1 | Activity lamp, active low |

## Verification
The bench builds the block with ON_CYC = 3 and OFF_CYC = 2, so one full flash lasts five cycles. With that setting the bench can check every lit and dark cycle of single flashes, merged flashes and sustained blinking against a modulo-five formula. Also within reach are all 32 combinations of mode, class flags, configuration bit and direction, and all four link/speed pairs, each with its expected lamp state worked out from the class rules. Link drop is tested in the middle of a flash, with a pending flash queued, and with pulses arriving while the link is down.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic [1:0] {
    BL_IDLE = 2'd0,
    BL_LIT  = 2'd1,
    BL_DARK = 2'd2
  } blink_st_e;
endpackage

// File: rtl/act_qualify.sv
module act_qualify (
  input  logic tx_act,
  input  logic rx_act,
  input  logic wol_mode,
  input  logic pkt_bcast,
  input  logic pkt_ucast,
  input  logic wol_ucast_only,
  input  logic link_up,
  output logic accept
);
  logic any_evt;
  logic class_ok;

  always_comb begin
    any_evt = tx_act | rx_act;
    if (!wol_mode)
      class_ok = 1'b1;
    else if (wol_ucast_only)
      class_ok = pkt_ucast;
    else
      class_ok = pkt_ucast | pkt_bcast;
    accept = link_up & any_evt & class_ok;
  end
endmodule

// File: rtl/blink_timer.sv
module blink_timer
  import led_pkg::*;
#(
  parameter int ON_CYC  = 1250000,
  parameter int OFF_CYC = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trig,
  output logic lit
);
  localparam int MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ON_LD  = CW'(ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LD = CW'(OFF_CYC - 1);

  blink_st_e     st;
  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      st   <= BL_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        BL_IDLE: begin
          if (trig) begin
            st  <= BL_LIT;
            cnt <= ON_LD;
          end
        end
        BL_LIT: begin
          if (trig) pend <= 1'b1;
          if (cnt == '0) begin
            st  <= BL_DARK;
            cnt <= OFF_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BL_DARK: begin
          if (cnt == '0) begin
            if (pend || trig) begin
              st   <= BL_LIT;
              cnt  <= ON_LD;
              pend <= 1'b0;
            end else begin
              st <= BL_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
            if (trig) pend <= 1'b1;
          end
        end
        default: begin
          st   <= BL_IDLE;
          cnt  <= '0;
          pend <= 1'b0;
        end
      endcase
    end
  end

  assign lit = (st == BL_LIT);
endmodule

// File: rtl/led_drive.sv
module led_drive (
  input  logic link_up,
  input  logic speed_100,
  input  logic act_lit,
  output logic link_led_n,
  output logic speed_led_n,
  output logic act_led_n
);
  always_comb begin
    link_led_n  = ~link_up;
    speed_led_n = ~(link_up & speed_100);
    act_led_n   = ~(link_up & act_lit);
  end
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int ON_CYC  = 1250000,
  parameter int OFF_CYC = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic speed_100,
  input  logic tx_act,
  input  logic rx_act,
  input  logic wol_mode,
  input  logic pkt_bcast,
  input  logic pkt_ucast,
  input  logic wol_ucast_only,
  output logic link_led_n,
  output logic speed_led_n,
  output logic act_led_n
);
  logic accept;
  logic act_lit;

  act_qualify u_qual (
    .tx_act         (tx_act),
    .rx_act         (rx_act),
    .wol_mode       (wol_mode),
    .pkt_bcast      (pkt_bcast),
    .pkt_ucast      (pkt_ucast),
    .wol_ucast_only (wol_ucast_only),
    .link_up        (link_up),
    .accept         (accept)
  );

  blink_timer #(
    .ON_CYC  (ON_CYC),
    .OFF_CYC (OFF_CYC)
  ) u_blink (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (link_up),
    .trig   (accept),
    .lit    (act_lit)
  );

  led_drive u_drive (
    .link_up     (link_up),
    .speed_100   (speed_100),
    .act_lit     (act_lit),
    .link_led_n  (link_led_n),
    .speed_led_n (speed_led_n),
    .act_led_n   (act_led_n)
  );
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk #(
  parameter int ON_CYC  = 1250000,
  parameter int OFF_CYC = 1250000
) (
  input logic clk,
  input logic rst_n,
  input logic link_up,
  input logic speed_100,
  input logic link_led_n,
  input logic speed_led_n,
  input logic act_led_n
);
  localparam int NW = $clog2(ON_CYC + 2);
  localparam int FW = $clog2(OFF_CYC + 1);
  localparam logic [NW-1:0] ON_SAT  = NW'(ON_CYC + 1);
  localparam logic [NW-1:0] ON_MAX  = NW'(ON_CYC);
  localparam logic [FW-1:0] OFF_SAT = FW'(OFF_CYC);

  logic [NW-1:0] on_run;
  logic [FW-1:0] off_run;

  always_ff @(posedge clk) begin
    if (!rst_n || act_led_n) on_run <= '0;
    else if (on_run != ON_SAT) on_run <= on_run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !link_up) off_run <= OFF_SAT;
    else if (!act_led_n) off_run <= '0;
    else if (off_run != OFF_SAT) off_run <= off_run + 1'b1;
  end

  // R2
  a_r2_link_follows: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> !link_led_n);
  // R3
  a_r3_speed_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && speed_100) |-> !speed_led_n);
  // R9
  a_r9_link_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> (act_led_n && speed_led_n && link_led_n));
  // R4
  a_r4_lit_width: assert property (@(posedge clk) disable iff (!rst_n)
    on_run <= ON_MAX);
  // R4 / R5
  a_r5_dark_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_led_n) |-> (off_run == OFF_SAT));
endmodule

bind phy_led_ctrl phy_led_chk #(
  .ON_CYC  (ON_CYC),
  .OFF_CYC (OFF_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_up     (link_up),
  .speed_100   (speed_100),
  .link_led_n  (link_led_n),
  .speed_led_n (speed_led_n),
  .act_led_n   (act_led_n)
);

// File: tb/sim_phy_led_ctrl.sv
`timescale 1ns/1ps
module sim_phy_led_ctrl;
  localparam int ON_C  = 3;
  localparam int OFF_C = 2;
  localparam int PER   = ON_C + OFF_C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0, speed_100 = 1'b0, tx_act = 1'b0, rx_act = 1'b0;
  logic wol_mode = 1'b0, pkt_bcast = 1'b0, pkt_ucast = 1'b0, wol_ucast_only = 1'b0;
  logic link_led_n, speed_led_n, act_led_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  phy_led_ctrl #(.ON_CYC(ON_C), .OFF_CYC(OFF_C)) u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
    .tx_act(tx_act), .rx_act(rx_act), .wol_mode(wol_mode),
    .pkt_bcast(pkt_bcast), .pkt_ucast(pkt_ucast), .wol_ucast_only(wol_ucast_only),
    .link_led_n(link_led_n), .speed_led_n(speed_led_n), .act_led_n(act_led_n)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string req, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // drive one pulse cycle; returns at the following negedge + 1ns with pulse cleared
  task automatic fire(input logic t, input logic r, input logic bc, input logic uc);
    tx_act = t; rx_act = r; pkt_bcast = bc; pkt_ucast = uc;
    @(negedge clk);
    tx_act = 0; rx_act = 0; pkt_bcast = 0; pkt_ucast = 0;
    #1;
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // reset
    link_up = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(act_led_n, 1'b1, "R10", "act dark in reset");
    chk(link_led_n, 1'b0, "R1", "link lit is low in reset");
    @(negedge clk); rst_n = 1'b1; #1;
    chk(act_led_n, 1'b1, "R10", "act dark after reset");

    // link/speed sweep
    for (int k = 0; k < 4; k++) begin
      link_up = k[1]; speed_100 = k[0];
      step();
      chk(link_led_n, ~k[1], "R2", $sformatf("link lamp k=%0d", k));
      chk(speed_led_n, ~(k[1] & k[0]), "R3", $sformatf("speed lamp k=%0d", k));
      if (!k[1]) chk(act_led_n, 1'b1, "R9", $sformatf("act dark link down k=%0d", k));
    end
    link_up = 1'b1; speed_100 = 1'b0;
    repeat (2) step();

    // class sweep: bit4 wol, bit3 ucast_only, bit2 bcast, bit1 ucast, bit0 direction
    for (int idx = 0; idx < 32; idx++) begin
      logic w, u, b, m, d, q;
      int lit_cnt;
      string req;
      w = idx[4]; u = idx[3]; b = idx[2]; m = idx[1]; d = idx[0];
      q = !w || m || (b && !u);
      req = !w ? "R6" : (u ? "R8" : "R7");
      wol_mode = w; wol_ucast_only = u;
      fire(d, !d, b, m);
      chk(act_led_n, ~q, req, $sformatf("first lit idx=%0d", idx));
      lit_cnt = (act_led_n == 1'b0) ? 1 : 0;
      for (int i = 2; i <= PER + 2; i++) begin
        step();
        if (!act_led_n) lit_cnt++;
      end
      chk_int(lit_cnt, q ? ON_C : 0, "R4", $sformatf("lit cycles idx=%0d", idx));
    end
    wol_mode = 0; wol_ucast_only = 0;

    // single flash shape (R4)
    begin
      logic exp;
      fire(1, 0, 0, 0);
      for (int i = 1; i <= PER + 3; i++) begin
        exp = (i <= ON_C) ? 1'b0 : 1'b1;
        chk(act_led_n, exp, "R4", $sformatf("single flash cycle %0d", i));
        step();
      end
    end

    // merge: second pulse during lit window (R5)
    begin
      int lit_cnt;
      tx_act = 1;
      @(negedge clk);
      #1;
      lit_cnt = 0;
      for (int i = 1; i <= 2 * PER + 2; i++) begin
        if (i == 1) tx_act = 0;
        if (i == 1) begin
          rx_act = 1;
          @(negedge clk);
          rx_act = 0;
          #1;
        end else begin
          step();
        end
        if (i + 1 == PER + 1) chk(act_led_n, 1'b0, "R5", "pending flash starts after dark");
        if (i + 1 == PER) chk(act_led_n, 1'b1, "R5", "dark before pending flash");
        if (!act_led_n) lit_cnt++;
      end
      chk_int(lit_cnt + 1, 2 * ON_C, "R5", "merged pulses give two flashes");
      repeat (3) step();
    end

    // sustained traffic (R5)
    begin
      logic exp;
      tx_act = 1;
      for (int i = 1; i <= 4 * PER; i++) begin
        step();
        exp = (((i - 1) % PER) < ON_C) ? 1'b0 : 1'b1;
        chk(act_led_n, exp, "R5", $sformatf("sustained cycle %0d", i));
      end
      tx_act = 0;
      repeat (PER + 2) step();
      chk(act_led_n, 1'b1, "R4", "dark after traffic stops");
    end

    // link drop mid flash with pending flash (R9)
    begin
      int lit_cnt;
      fire(1, 0, 0, 0);
      fire(0, 1, 0, 0);
      link_up = 0; #1;
      chk(act_led_n, 1'b1, "R9", "act dark on link drop");
      chk(speed_led_n, 1'b1, "R9", "speed dark on link drop");
      fire(1, 1, 1, 1);
      step();
      link_up = 1;
      lit_cnt = 0;
      for (int i = 0; i < 2 * PER; i++) begin
        step();
        if (!act_led_n) lit_cnt++;
      end
      chk_int(lit_cnt, 0, "R9", "no resumed flash after link return");
    end

    summary();
    $finish;
  end
endmodule